// File: doc/BRIEF.md
# Line Switch Control Logic

This block turns a three-bit control command into drive enables for the four switch groups of a subscriber line interface: the break pair, the ringing-return switch, the ringing switch and the test pair. The command is decoded into one of three line states (talk, ringing, all-off). A supply lockout and a latch-enable input decide when the command is accepted, and an active-low shutdown input forces the switches open. The ringing switch does not open on command. It stays closed until a current zero-crossing pulse arrives, and only then opens. As a result, a direct move from ringing to talk briefly closes the break pair alongside the still-closed ringing switch (make-before-break). A move through all-off first lets the ringing switch open before talk is applied (break-before-make).

Two state machines do the work. The lockout machine has three states: `LK_DOWN` (supply not valid), `LK_WAIT` (supply valid, latch not yet low) and `LK_ARMED`. It moves from `LK_DOWN` to `LK_WAIT` or `LK_ARMED` on supply-valid, depending on the latch level at that moment. It moves from `LK_WAIT` to `LK_ARMED` when the latch first goes low. It falls back to `LK_DOWN` from any state when the supply drops. The switch machine has six states, each of which is reported on `state_code`: `SW_OFF`, `SW_TALK`, `SW_RING`, `SW_MBB` (talk applied, ringing switch awaiting zero-crossing), `SW_DRAIN` (off applied, ringing switch awaiting zero-crossing) and `SW_BAD` (undecoded command, all open). Leaving `SW_RING` for talk, off or an undecoded command goes to `SW_MBB` or `SW_DRAIN` unless a zero-crossing arrives in the same cycle. A zero-crossing moves `SW_MBB` to `SW_TALK` and `SW_DRAIN` to `SW_OFF`. Once the lockout is armed, a high latch freezes the switch machine in its present state. A pending zero-crossing still completes during the freeze.

Top module: `line_switch_ctrl`

## Requirements
- R1: When `supply_ok` is sampled low, all four enables are 0 and `state_code` is 0 from the next cycle on. This applies even if the ringing switch was closed, and the command inputs are ignored meanwhile.
- R2: After `supply_ok` rises with `latch_hold` high, all enables stay 0 (`state_code` 0) while `latch_hold` stays high. The first cycle sampled with `latch_hold` low applies the command one cycle later.
- R3: If `latch_hold` is low in the first cycle that `supply_ok` is sampled high, the decoded command state appears on the next cycle.
- R4: Command {cmd_ring,cmd_test_in,cmd_test_out} = 000 gives talk: only `brk_en` is 1, and `state_code` is 1.
- R5: Command 100 gives ringing: `rret_en` and `ring_en` are 1, the others 0, and `state_code` is 2.
- R6: Command 101 gives all-off (`state_code` 0). Command 111 also gives all-off when `ALT_OFF_EN` is 1. Every other code, including 111 when `ALT_OFF_EN` is 0, opens all switches and reports `state_code` 5.
- R7: While `shut_n` is sampled low, `brk_en`, `rret_en` and `tst_en` are 0 from the next cycle. An already-closed ringing switch stays closed (`state_code` 4) until a zero-crossing. Once `shut_n` is high again, the command pins take control on the next cycle.
- R8: When the ringing state is left, `rret_en` drops on the next cycle. `ring_en` stays 1 until `zc_pulse` is sampled high and drops on the cycle after. Leaving for all-off reports `state_code` 4 while the zero-crossing is awaited.
- R9: A direct change from ringing to talk sets `brk_en` on the next cycle while `ring_en` is still 1 (`state_code` 3), until the zero-crossing.
- R10: Once the lockout has been released, a high `latch_hold` freezes the present switch state against command changes. A pending ringing-switch release still completes on `zc_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_ring | input | 1 | Command bit 2 (ringing select) |
| cmd_test_in | input | 1 | Command bit 1 |
| cmd_test_out | input | 1 | Command bit 0 |
| latch_hold | input | 1 | Latch enable; high (or undriven, pulled to 1) blocks command decode |
| shut_n | input | 1 | Active-low shutdown override |
| supply_ok | input | 1 | Supply valid indication |
| zc_pulse | input | 1 | Single-cycle ringing-current zero-crossing pulse |
| brk_en | output | 1 | Break pair enable |
| rret_en | output | 1 | Ringing-return switch enable |
| ring_en | output | 1 | Ringing switch enable |
| tst_en | output | 1 | Test pair enable |
| state_code | output | 3 | Switch state: 0 off, 1 talk, 2 ringing, 3 make-before-break, 4 ringing release pending, 5 undecoded |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it are sampled. This holds for command decode, lockout release, shutdown and the zero-crossing release, because all of them pass through the switch state register and nothing else. The bench changes inputs just after a falling edge, lets one rising edge pass, and compares every output at the following falling edge. The held states (pending zero-crossing, frozen latch, locked supply) are checked again after an extra edge with no change, so that a late transition cannot escape detection.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int CMD_W   = 3;
    localparam int STATE_W = 3;

    // switch state; the numeric values are the reported state code
    typedef enum logic [STATE_W-1:0] {
        SW_OFF   = 3'd0,
        SW_TALK  = 3'd1,
        SW_RING  = 3'd2,
        SW_MBB   = 3'd3,
        SW_DRAIN = 3'd4,
        SW_BAD   = 3'd5
    } sw_state_e;

    typedef enum logic [1:0] {
        LK_DOWN  = 2'd0,
        LK_WAIT  = 2'd1,
        LK_ARMED = 2'd2
    } lock_state_e;

    typedef enum logic [2:0] {
        TGT_OFF  = 3'd0,
        TGT_TALK = 3'd1,
        TGT_RING = 3'd2,
        TGT_BAD  = 3'd3,
        TGT_HOLD = 3'd4
    } target_e;

    typedef struct packed {
        logic brk;
        logic rret;
        logic ring;
        logic tst;
    } drive_t;

    // command codes, ordered {ring, test_in, test_out}
    localparam logic [CMD_W-1:0] CODE_TALK    = 3'b000;
    localparam logic [CMD_W-1:0] CODE_RING    = 3'b100;
    localparam logic [CMD_W-1:0] CODE_OFF     = 3'b101;
    localparam logic [CMD_W-1:0] CODE_ALT_OFF = 3'b111;

endpackage

// File: rtl/lsc_lockout.sv
module lsc_lockout
    import lsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        supply_ok,
    input  logic        latch_hold,
    output lock_state_e lk_state,
    output logic        cmd_live,
    output logic        cmd_freeze
);

    lock_state_e lk_q;
    lock_state_e lk_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= LK_DOWN;
        end else begin
            lk_q <= lk_d;
        end
    end

    // next state
    always_comb begin
        lk_d = lk_q;
        if (!supply_ok) begin
            lk_d = LK_DOWN;
        end else begin
            unique case (lk_q)
                LK_DOWN:  lk_d = latch_hold ? LK_WAIT : LK_ARMED;
                LK_WAIT:  lk_d = latch_hold ? LK_WAIT : LK_ARMED;
                LK_ARMED: lk_d = LK_ARMED;
                default:  lk_d = LK_DOWN;
            endcase
        end
    end

    // qualifiers for the command decoder
    always_comb begin
        cmd_live   = supply_ok && !latch_hold;
        cmd_freeze = supply_ok && latch_hold && (lk_q == LK_ARMED);
        lk_state   = lk_q;
    end

    // R2: a lockout still waiting with latch high never arms on the next edge
    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_WAIT && supply_ok && latch_hold) |=> (lk_q == LK_WAIT));

endmodule

// File: rtl/lsc_decode.sv
module lsc_decode
    import lsc_pkg::*;
#(
    parameter bit ALT_OFF_EN = 1'b0
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic             cmd_live,
    input  logic             cmd_freeze,
    input  logic             shut_n,
    output target_e          tgt
);

    logic alt_hit;

    generate
        if (ALT_OFF_EN) begin : g_alt_off
            assign alt_hit = (cmd == CODE_ALT_OFF);
        end else begin : g_no_alt_off
            assign alt_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        tgt = TGT_OFF;
        if (!shut_n) begin
            tgt = TGT_OFF;
        end else if (cmd_freeze) begin
            tgt = TGT_HOLD;
        end else if (!cmd_live) begin
            tgt = TGT_OFF;
        end else begin
            case (cmd)
                CODE_TALK: tgt = TGT_TALK;
                CODE_RING: tgt = TGT_RING;
                CODE_OFF:  tgt = TGT_OFF;
                default:   tgt = alt_hit ? TGT_OFF : TGT_BAD;
            endcase
        end
    end

endmodule

// File: rtl/lsc_switch_fsm.sv
module lsc_switch_fsm
    import lsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  target_e   tgt,
    input  logic      zc_pulse,
    input  logic      force_clr,
    output sw_state_e sw_state,
    output drive_t    drv
);

    sw_state_e state_q;
    sw_state_e state_d;
    logic      ring_wait;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        ring_wait = (state_q == SW_RING || state_q == SW_MBB || state_q == SW_DRAIN)
                    && !zc_pulse;
        state_d   = state_q;
        if (force_clr) begin
            state_d = SW_OFF;
        end else begin
            unique case (tgt)
                TGT_HOLD: begin
                    if (state_q == SW_MBB && zc_pulse) begin
                        state_d = SW_TALK;
                    end else if (state_q == SW_DRAIN && zc_pulse) begin
                        state_d = SW_OFF;
                    end else begin
                        state_d = state_q;
                    end
                end
                TGT_RING: state_d = SW_RING;
                TGT_TALK: state_d = ring_wait ? SW_MBB   : SW_TALK;
                TGT_OFF:  state_d = ring_wait ? SW_DRAIN : SW_OFF;
                TGT_BAD:  state_d = ring_wait ? SW_DRAIN : SW_BAD;
                default:  state_d = SW_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        drv = '0;
        unique case (state_q)
            SW_OFF:   drv = '0;
            SW_TALK:  drv = '{brk: 1'b1, rret: 1'b0, ring: 1'b0, tst: 1'b0};
            SW_RING:  drv = '{brk: 1'b0, rret: 1'b1, ring: 1'b1, tst: 1'b0};
            SW_MBB:   drv = '{brk: 1'b1, rret: 1'b0, ring: 1'b1, tst: 1'b0};
            SW_DRAIN: drv = '{brk: 1'b0, rret: 1'b0, ring: 1'b1, tst: 1'b0};
            SW_BAD:   drv = '0;
            default:  drv = '0;
        endcase
        sw_state = state_q;
    end

    // R8
    ring_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv.ring) |-> ($past(zc_pulse) || $past(force_clr)));

    // R9
    mbb_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_RING && tgt == TGT_TALK && !zc_pulse && !force_clr)
        |=> (drv.brk && drv.ring));

endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
    import lsc_pkg::*;
#(
    parameter bit ALT_OFF_EN = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_ring,
    input  logic               cmd_test_in,
    input  logic               cmd_test_out,
    input  logic               latch_hold,
    input  logic               shut_n,
    input  logic               supply_ok,
    input  logic               zc_pulse,
    output logic               brk_en,
    output logic               rret_en,
    output logic               ring_en,
    output logic               tst_en,
    output logic [STATE_W-1:0] state_code
);

    lock_state_e lk_state;
    logic        cmd_live;
    logic        cmd_freeze;
    target_e     tgt;
    sw_state_e   sw_state;
    drive_t      drv;

    lsc_lockout u_lockout (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .latch_hold (latch_hold),
        .lk_state   (lk_state),
        .cmd_live   (cmd_live),
        .cmd_freeze (cmd_freeze)
    );

    lsc_decode #(
        .ALT_OFF_EN (ALT_OFF_EN)
    ) u_decode (
        .cmd        ({cmd_ring, cmd_test_in, cmd_test_out}),
        .cmd_live   (cmd_live),
        .cmd_freeze (cmd_freeze),
        .shut_n     (shut_n),
        .tgt        (tgt)
    );

    lsc_switch_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tgt        (tgt),
        .zc_pulse   (zc_pulse),
        .force_clr  (!supply_ok),
        .sw_state   (sw_state),
        .drv        (drv)
    );

    always_comb begin
        brk_en     = drv.brk;
        rret_en    = drv.rret;
        ring_en    = drv.ring;
        tst_en     = drv.tst;
        state_code = sw_state;
    end

    // R1
    supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!brk_en && !rret_en && !ring_en && !tst_en));

    // R2
    lockout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && latch_hold && lk_state != LK_ARMED) |=> (state_code == SW_OFF));

    // R7
    shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shut_n && supply_ok) |=> (!brk_en && !rret_en && !tst_en));

    // R5
    ring_return_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_en && rret_en));

endmodule

// File: tb/line_switch_ctrl_tb.sv
module line_switch_ctrl_tb_top;

    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_ring, cmd_test_in, cmd_test_out;
    logic       latch_hold, shut_n, supply_ok, zc_pulse;
    logic       brk_en, rret_en, ring_en, tst_en;
    logic [2:0] state_code;
    logic       a_brk, a_rret, a_ring, a_tst;
    logic [2:0] a_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    line_switch_ctrl #(.ALT_OFF_EN(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_ring(cmd_ring), .cmd_test_in(cmd_test_in), .cmd_test_out(cmd_test_out),
        .latch_hold(latch_hold), .shut_n(shut_n), .supply_ok(supply_ok), .zc_pulse(zc_pulse),
        .brk_en(brk_en), .rret_en(rret_en), .ring_en(ring_en), .tst_en(tst_en),
        .state_code(state_code)
    );

    line_switch_ctrl #(.ALT_OFF_EN(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_ring(cmd_ring), .cmd_test_in(cmd_test_in), .cmd_test_out(cmd_test_out),
        .latch_hold(latch_hold), .shut_n(shut_n), .supply_ok(supply_ok), .zc_pulse(zc_pulse),
        .brk_en(a_brk), .rret_en(a_rret), .ring_en(a_ring), .tst_en(a_tst),
        .state_code(a_code)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cmd(input logic [2:0] c);
        {cmd_ring, cmd_test_in, cmd_test_out} = c;
    endtask

    task automatic zc_step();
        zc_pulse = 1'b1;
        step();
        zc_pulse = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [2:0] e_code,
                       input logic e_brk, input logic e_rret, input logic e_ring);
        checks++;
        if ({state_code, brk_en, rret_en, ring_en, tst_en} !==
            {e_code, e_brk, e_rret, e_ring, 1'b0}) begin
            errors++;
            $display("FAIL %s: got code=%0d brk=%b rret=%b ring=%b tst=%b, expected code=%0d brk=%b rret=%b ring=%b tst=0",
                     tag, state_code, brk_en, rret_en, ring_en, tst_en,
                     e_code, e_brk, e_rret, e_ring);
        end
    endtask

    task automatic chk_alt(input string tag, input logic [2:0] e_code);
        checks++;
        if ({a_code, a_brk, a_rret, a_ring, a_tst} !== {e_code, 4'b0000}) begin
            errors++;
            $display("FAIL %s (alt variant): got code=%0d enables=%b%b%b%b, expected code=%0d enables=0000",
                     tag, a_code, a_brk, a_rret, a_ring, a_tst, e_code);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        set_cmd(3'b100);
        latch_hold = 1'b1; shut_n = 1'b1; supply_ok = 1'b0; zc_pulse = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset state", 3'd0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_lockout();
        set_cmd(3'b100);
        step();
        chk("R1 supply low ignores command", 3'd0, 0, 0, 0);
        supply_ok = 1'b1;
        step();
        chk("R2 locked with latch high", 3'd0, 0, 0, 0);
        step();
        chk("R2 still locked", 3'd0, 0, 0, 0);
        latch_hold = 1'b0;
        step();
        chk("R2 R5 release into ringing", 3'd2, 0, 1, 1);
    endtask

    task automatic t_make_before_break();
        set_cmd(3'b000);
        step();
        chk("R9 ringing to talk overlap", 3'd3, 1, 0, 1);
        step();
        chk("R8 ringing switch waits for zero-crossing", 3'd3, 1, 0, 1);
        zc_step();
        chk("R8 R4 zero-crossing completes talk", 3'd1, 1, 0, 0);
    endtask

    task automatic t_break_before_make();
        set_cmd(3'b100);
        step();
        chk("R5 ringing", 3'd2, 0, 1, 1);
        set_cmd(3'b101);
        step();
        chk("R8 off pending release", 3'd4, 0, 0, 1);
        step();
        chk("R8 still pending", 3'd4, 0, 0, 1);
        zc_step();
        chk("R6 all-off after zero-crossing", 3'd0, 0, 0, 0);
        set_cmd(3'b000);
        step();
        chk("R4 talk after break", 3'd1, 1, 0, 0);
    endtask

    task automatic t_shutdown();
        set_cmd(3'b100);
        step();
        chk("R5 ringing before shutdown", 3'd2, 0, 1, 1);
        shut_n = 1'b0;
        step();
        chk("R7 shutdown keeps closed ringing switch", 3'd4, 0, 0, 1);
        set_cmd(3'b000);
        step();
        chk("R7 command ignored during shutdown", 3'd4, 0, 0, 1);
        zc_step();
        chk("R7 all-off after zero-crossing", 3'd0, 0, 0, 0);
        shut_n = 1'b1;
        step();
        chk("R7 pins regain control", 3'd1, 1, 0, 0);
    endtask

    task automatic t_freeze();
        latch_hold = 1'b1;
        set_cmd(3'b100);
        step();
        chk("R10 talk frozen", 3'd1, 1, 0, 0);
        latch_hold = 1'b0;
        step();
        chk("R10 unfrozen ringing", 3'd2, 0, 1, 1);
        latch_hold = 1'b1;
        set_cmd(3'b000);
        step();
        chk("R10 ringing frozen", 3'd2, 0, 1, 1);
        zc_step();
        chk("R10 zero-crossing no effect while frozen in ringing", 3'd2, 0, 1, 1);
        latch_hold = 1'b0;
        step();
        chk("R9 overlap after unfreeze", 3'd3, 1, 0, 1);
        latch_hold = 1'b1;
        zc_step();
        chk("R10 pending release completes while frozen", 3'd1, 1, 0, 0);
        latch_hold = 1'b0;
    endtask

    task automatic t_codes();
        set_cmd(3'b111);
        step();
        chk("R6 code 111 undecoded", 3'd5, 0, 0, 0);
        chk_alt("R6 code 111 all-off", 3'd0);
        set_cmd(3'b110);
        step();
        chk("R6 code 110 undecoded", 3'd5, 0, 0, 0);
        chk_alt("R6 code 110 undecoded", 3'd5);
        set_cmd(3'b011);
        step();
        chk("R6 code 011 undecoded", 3'd5, 0, 0, 0);
        set_cmd(3'b101);
        step();
        chk("R6 code 101 all-off", 3'd0, 0, 0, 0);
        chk_alt("R6 code 101 all-off", 3'd0);
    endtask

    task automatic t_supply();
        set_cmd(3'b100);
        step();
        chk("R5 ringing before supply loss", 3'd2, 0, 1, 1);
        supply_ok = 1'b0;
        step();
        chk("R1 supply loss opens ringing switch", 3'd0, 0, 0, 0);
        set_cmd(3'b000);
        step();
        chk("R1 command ignored without supply", 3'd0, 0, 0, 0);
        latch_hold = 1'b1;
        supply_ok = 1'b1;
        set_cmd(3'b100);
        step();
        chk("R2 relocked after supply return", 3'd0, 0, 0, 0);
        step();
        chk("R2 still relocked", 3'd0, 0, 0, 0);
        latch_hold = 1'b0;
        step();
        chk("R2 release after relock", 3'd2, 0, 1, 1);
        supply_ok = 1'b0;
        set_cmd(3'b000);
        step();
        chk("R1 off again", 3'd0, 0, 0, 0);
        supply_ok = 1'b1;
        step();
        chk("R3 latch low at supply valid goes straight to talk", 3'd1, 1, 0, 0);
    endtask

    initial begin
        t_reset();
        t_lockout();
        t_make_before_break();
        t_break_before_make();
        t_shutdown();
        t_freeze();
        t_codes();
        t_supply();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule